// File: doc/BRIEF.md
# Indexed, Increment and Pair Load/Store Address Generator

This block computes memory addresses for three families of load/store operations. In register-indexed mode the access address is the base register plus an index register shifted left by a 2-bit amount. The index can be used whole, or its low 32 bits can be zero-extended first. In auto-increment mode a signed 5-bit immediate, shifted by the same 2-bit amount, forms a step. The access goes either to the old base (post-increment) or to the stepped base (pre-increment). In both forms the stepped base is returned for write-back to the base register. In pair mode a 2-bit offset field is scaled by 16 for doubleword pairs or by 8 for word pairs. The block then issues two consecutive element addresses on two output beats.

Requests enter through a valid/ready handshake, and results leave through a registered valid/ready output stage. Encodings that are not allowed raise an illegal flag on the first beat. They produce no write-back and no second beat. These encodings are register overlaps, doubleword forms on a 32-bit datapath, the reserved mode, and pairs of bytes or halfwords.

Top module: `lsu_addr_gen`

## Requirements
- R1: Mode 0 (indexed) gives the address base + (index << shift), with shift in 0..3 and the index taken as the full XLEN-bit value when zext is 0.
- R2: In mode 0 with zext = 1, the index is replaced by its low 32 bits zero-extended before shifting.
- R3: Mode 1 (increment) forms step = sign-extended imm5 << shift. With pre = 0 the address is base, and with pre = 1 it is base + step.
- R4: A legal mode 1 access asserts wb_en on the first beat, with wb_reg = rs and wb_data = base + step, for both loads and stores.
- R5: A mode 1 load (is_load = 1) whose rd equals rs is illegal. A mode 1 store with rd equal to rs is legal.
- R6: Mode 2 (pair) uses size 3 (8-byte elements, offset sh2 << 4) or size 2 (4-byte elements, offset sh2 << 3). The first beat carries base + offset. The second beat, flagged by out_second = 1, carries that address plus the element size.
- R7: A mode 2 load is illegal unless rs, rd and rd2 are all different. A mode 2 store is not checked for overlap.
- R8: With XLEN = 32, any access of size 3 (doubleword) in any mode is illegal.
- R9: An illegal request gives one output beat with illegal = 1, with wb_en = 0 and no second beat.
- R10: While out_valid = 1 and out_ready = 0, every output holds its value and req_ready is 0.
- R11: After reset, out_valid = 0, wb_en = 0, illegal = 0 and req_ready = 1.
- R12: Mode 3 is reserved and illegal. Mode 2 with size 0 or 1 is illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when high |
| req_mode | input | 2 | 0 indexed, 1 increment, 2 pair, 3 reserved |
| req_size | input | 2 | Element size: 0 byte, 1 half, 2 word, 3 doubleword |
| req_is_load | input | 1 | 1 for a load, 0 for a store |
| req_pre | input | 1 | Increment mode: 1 pre-increment, 0 post-increment |
| req_zext | input | 1 | Indexed mode: zero-extend index low word |
| req_base | input | XLEN | Base register value |
| req_index | input | XLEN | Index register value |
| req_shift | input | 2 | Shift amount for index or immediate |
| req_imm5 | input | 5 | Signed increment immediate |
| req_sh2 | input | 2 | Pair offset field |
| req_rd | input | 5 | First data register number |
| req_rd2 | input | 5 | Second data register number (pair) |
| req_rs | input | 5 | Base register number |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Consumer takes the beat |
| out_addr | output | XLEN | Access address of this beat |
| out_second | output | 1 | Beat is the second address of a pair |
| wb_en | output | 1 | Base write-back requested with this beat |
| wb_reg | output | 5 | Register to receive the write-back |
| wb_data | output | XLEN | Updated base value |
| illegal | output | 1 | Request is an illegal encoding |

## Verification
A wrong step or offset computation shows up as a bad out_addr or wb_data on the first beat, one clock after acceptance. A stale pending second beat would appear as an extra beat with out_second = 1, one beat later, or as req_ready staying low when it should be high. A missed overlap or width check appears as illegal = 0 together with an unexpected wb_en or second beat on the same or the next cycle.

// File: rtl/lsu_ag_pkg.sv
package lsu_ag_pkg;
  typedef enum logic [1:0] {
    AG_INDEXED = 2'd0,
    AG_INCR    = 2'd1,
    AG_PAIR    = 2'd2,
    AG_RSVD    = 2'd3
  } ag_mode_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DBL  = 2'd3
  } ag_size_e;

  localparam int REGW = 5;
endpackage

// File: rtl/lsu_ag_index.sv
module lsu_ag_index #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] base,
  input  logic [XLEN-1:0] index,
  input  logic [1:0]      shift,
  input  logic            zext,
  output logic [XLEN-1:0] addr
);
  logic [XLEN-1:0] idx;

  generate
    if (XLEN > 32) begin : g_wide
      assign idx = zext ? {{(XLEN-32){1'b0}}, index[31:0]} : index;
    end else begin : g_narrow
      logic unused_zext;
      assign unused_zext = zext;
      assign idx = index;
    end
  endgenerate

  assign addr = base + (idx << shift);
endmodule

// File: rtl/lsu_ag_incr.sv
module lsu_ag_incr #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] base,
  input  logic [4:0]      imm5,
  input  logic [1:0]      shift,
  input  logic            pre,
  output logic [XLEN-1:0] addr,
  output logic [XLEN-1:0] next_base
);
  logic [XLEN-1:0] step;

  assign step      = {{(XLEN-5){imm5[4]}}, imm5} << shift;
  assign next_base = base + step;
  assign addr      = pre ? next_base : base;
endmodule

// File: rtl/lsu_ag_pair.sv
module lsu_ag_pair #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] base,
  input  logic [1:0]      sh2,
  input  logic            dbl,
  output logic [XLEN-1:0] addr1,
  output logic [XLEN-1:0] addr2
);
  localparam logic [XLEN-1:0] WORD_BYTES = XLEN'(4);
  localparam logic [XLEN-1:0] DBL_BYTES  = XLEN'(8);

  logic [XLEN-1:0] offs;

  assign offs  = dbl ? (XLEN'(sh2) << 4) : (XLEN'(sh2) << 3);
  assign addr1 = base + offs;
  assign addr2 = addr1 + (dbl ? DBL_BYTES : WORD_BYTES);
endmodule

// File: rtl/lsu_ag_legal.sv
module lsu_ag_legal
  import lsu_ag_pkg::*;
#(
  parameter bit WIDE = 1'b1
) (
  input  logic [1:0]      mode,
  input  logic [1:0]      size,
  input  logic            is_load,
  input  logic [REGW-1:0] rd,
  input  logic [REGW-1:0] rd2,
  input  logic [REGW-1:0] rs,
  output logic            illegal
);
  logic dbl_bad;
  logic mode_bad;

  assign dbl_bad = !WIDE && (size == SZ_DBL);

  always_comb begin
    mode_bad = 1'b0;
    unique case (ag_mode_e'(mode))
      AG_INDEXED: mode_bad = 1'b0;
      AG_INCR:    mode_bad = is_load && (rd == rs);
      AG_PAIR:    mode_bad = (size == SZ_BYTE) || (size == SZ_HALF) ||
                             (is_load && ((rs == rd) || (rs == rd2) || (rd == rd2)));
      default:    mode_bad = 1'b1;
    endcase
  end

  assign illegal = dbl_bad || mode_bad;
endmodule

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen
  import lsu_ag_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [1:0]      req_mode,
  input  logic [1:0]      req_size,
  input  logic            req_is_load,
  input  logic            req_pre,
  input  logic            req_zext,
  input  logic [XLEN-1:0] req_base,
  input  logic [XLEN-1:0] req_index,
  input  logic [1:0]      req_shift,
  input  logic [4:0]      req_imm5,
  input  logic [1:0]      req_sh2,
  input  logic [4:0]      req_rd,
  input  logic [4:0]      req_rd2,
  input  logic [4:0]      req_rs,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [XLEN-1:0] out_addr,
  output logic            out_second,
  output logic            wb_en,
  output logic [4:0]      wb_reg,
  output logic [XLEN-1:0] wb_data,
  output logic            illegal
);
  localparam bit WIDE = (XLEN >= 64);

  logic [XLEN-1:0] idx_addr, inc_addr, inc_next, pr_addr1, pr_addr2;
  logic            bad;
  logic [XLEN-1:0] first_c;
  logic            wb_c;
  logic            pair_c;

  logic            pend_q;
  logic [XLEN-1:0] pend_addr_q;

  lsu_ag_index #(.XLEN(XLEN)) u_index (
    .base(req_base), .index(req_index), .shift(req_shift),
    .zext(req_zext), .addr(idx_addr)
  );

  lsu_ag_incr #(.XLEN(XLEN)) u_incr (
    .base(req_base), .imm5(req_imm5), .shift(req_shift),
    .pre(req_pre), .addr(inc_addr), .next_base(inc_next)
  );

  lsu_ag_pair #(.XLEN(XLEN)) u_pair (
    .base(req_base), .sh2(req_sh2), .dbl(req_size == SZ_DBL),
    .addr1(pr_addr1), .addr2(pr_addr2)
  );

  lsu_ag_legal #(.WIDE(WIDE)) u_legal (
    .mode(req_mode), .size(req_size), .is_load(req_is_load),
    .rd(req_rd), .rd2(req_rd2), .rs(req_rs), .illegal(bad)
  );

  always_comb begin
    first_c = idx_addr;
    wb_c    = 1'b0;
    pair_c  = 1'b0;
    case (ag_mode_e'(req_mode))
      AG_INCR: begin
        first_c = inc_addr;
        wb_c    = !bad;
      end
      AG_PAIR: begin
        first_c = pr_addr1;
        pair_c  = !bad;
      end
      default: first_c = idx_addr;
    endcase
  end

  logic accept;
  logic advance;

  assign req_ready = !pend_q && (!out_valid || out_ready);
  assign accept    = req_valid && req_ready;
  assign advance   = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_addr    <= '0;
      out_second  <= 1'b0;
      wb_en       <= 1'b0;
      wb_reg      <= '0;
      wb_data     <= '0;
      illegal     <= 1'b0;
      pend_q      <= 1'b0;
      pend_addr_q <= '0;
    end else if (accept) begin
      out_valid   <= 1'b1;
      out_addr    <= first_c;
      out_second  <= 1'b0;
      wb_en       <= wb_c;
      wb_reg      <= req_rs;
      wb_data     <= inc_next;
      illegal     <= bad;
      pend_q      <= pair_c;
      pend_addr_q <= pr_addr2;
    end else if (advance) begin
      if (pend_q) begin
        out_addr   <= pend_addr_q;
        out_second <= 1'b1;
        wb_en      <= 1'b0;
        illegal    <= 1'b0;
        pend_q     <= 1'b0;
      end else begin
        out_valid  <= 1'b0;
        out_second <= 1'b0;
        wb_en      <= 1'b0;
        illegal    <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/lsu_addr_gen_chk.sv
module lsu_addr_gen_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst,
  input logic            req_ready,
  input logic            out_valid,
  input logic            out_ready,
  input logic [XLEN-1:0] out_addr,
  input logic            out_second,
  input logic            wb_en,
  input logic            illegal
);
  logic [XLEN-1:0] prev_addr;
  logic [XLEN-1:0] diff;

  always_ff @(posedge clk) prev_addr <= out_addr;
  assign diff = out_addr - prev_addr;

  p_illegal_no_wb_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && illegal) |-> !wb_en);

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_second)));

  p_no_accept_r10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !req_ready);

  p_pair_step_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_second) |-> ((diff == XLEN'(4)) || (diff == XLEN'(8))));

  p_second_clean_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_second) |-> (!wb_en && !illegal));

  p_wb_first_r4: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> (out_valid && !out_second));
endmodule

bind lsu_addr_gen lsu_addr_gen_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst(rst), .req_ready(req_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_addr(out_addr), .out_second(out_second),
  .wb_en(wb_en), .illegal(illegal)
);

// File: tb/lsu_addr_gen_test.sv
`timescale 1ns/1ps
module lsu_addr_gen_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic        req_valid, req_ready, req_is_load, req_pre, req_zext;
  logic [1:0]  req_mode, req_size, req_shift, req_sh2;
  logic [63:0] req_base, req_index;
  logic [4:0]  req_imm5, req_rd, req_rd2, req_rs;
  logic        out_valid, out_ready, out_second, wb_en, illegal;
  logic [63:0] out_addr, wb_data;
  logic [4:0]  wb_reg;

  lsu_addr_gen #(.XLEN(64)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_mode(req_mode), .req_size(req_size), .req_is_load(req_is_load),
    .req_pre(req_pre), .req_zext(req_zext), .req_base(req_base),
    .req_index(req_index), .req_shift(req_shift), .req_imm5(req_imm5),
    .req_sh2(req_sh2), .req_rd(req_rd), .req_rd2(req_rd2), .req_rs(req_rs),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
    .out_second(out_second), .wb_en(wb_en), .wb_reg(wb_reg),
    .wb_data(wb_data), .illegal(illegal)
  );

  logic        n_valid, n_ready, n_second, n_wb, n_ill;
  logic [1:0]  n_mode, n_size;
  logic [31:0] n_base, n_index, n_addr, n_wbd;
  logic [4:0]  n_wbr;

  lsu_addr_gen #(.XLEN(32)) uut32 (
    .clk(clk), .rst(rst), .req_valid(n_valid), .req_ready(n_ready),
    .req_mode(n_mode), .req_size(n_size), .req_is_load(1'b1),
    .req_pre(1'b0), .req_zext(1'b0), .req_base(n_base),
    .req_index(n_index), .req_shift(2'd2), .req_imm5(5'd0),
    .req_sh2(2'd0), .req_rd(5'd2), .req_rd2(5'd3), .req_rs(5'd1),
    .out_valid(), .out_ready(1'b1), .out_addr(n_addr),
    .out_second(n_second), .wb_en(n_wb), .wb_reg(n_wbr),
    .wb_data(n_wbd), .illegal(n_ill)
  );

  typedef struct packed {
    logic [1:0]  mode;
    logic [1:0]  size;
    logic        ld;
    logic        pre;
    logic        zx;
    logic [63:0] base;
    logic [63:0] idx;
    logic [1:0]  sh;
    logic [4:0]  imm;
    logic [1:0]  sh2;
    logic [4:0]  rd;
    logic [4:0]  rd2;
    logic [4:0]  rs;
    logic [63:0] a1;
    logic [63:0] a2;
    logic        two;
    logic        wb;
    logic [63:0] wbd;
    logic        ill;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t TBL [NV] = '{
    // R1 indexed, shift 2
    '{2'd0, 2'd3, 1'b1, 1'b0, 1'b0, 64'h1000, 64'h10, 2'd2, 5'd0, 2'd0, 5'd2, 5'd0, 5'd1,
      64'h1040, 64'h0, 1'b0, 1'b0, 64'h0, 1'b0},
    // R1 indexed, negative index, shift 3
    '{2'd0, 2'd2, 1'b0, 1'b0, 1'b0, 64'h1000, 64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 5'd0, 2'd0, 5'd2, 5'd0, 5'd1,
      64'hFF8, 64'h0, 1'b0, 1'b0, 64'h0, 1'b0},
    // R2 zero-extended index low word
    '{2'd0, 2'd2, 1'b1, 1'b0, 1'b1, 64'h1000, 64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 5'd0, 2'd0, 5'd2, 5'd0, 5'd1,
      64'h8_0000_0FF8, 64'h0, 1'b0, 1'b0, 64'h0, 1'b0},
    // R1 indexed, shift 0
    '{2'd0, 2'd0, 1'b1, 1'b0, 1'b0, 64'h500, 64'h7, 2'd0, 5'd0, 2'd0, 5'd2, 5'd0, 5'd1,
      64'h507, 64'h0, 1'b0, 1'b0, 64'h0, 1'b0},
    // R3 R4 post-increment load, step 10
    '{2'd1, 2'd2, 1'b1, 1'b0, 1'b0, 64'h2000, 64'h0, 2'd1, 5'd5, 2'd0, 5'd4, 5'd0, 5'd3,
      64'h2000, 64'h0, 1'b0, 1'b1, 64'h200A, 1'b0},
    // R3 R4 R5 pre-increment store, step -16, rd==rs allowed
    '{2'd1, 2'd3, 1'b0, 1'b1, 1'b0, 64'h2000, 64'h0, 2'd2, 5'h1C, 2'd0, 5'd7, 5'd0, 5'd7,
      64'h1FF0, 64'h0, 1'b0, 1'b1, 64'h1FF0, 1'b0},
    // R5 R9 increment load rd==rs illegal
    '{2'd1, 2'd2, 1'b1, 1'b1, 1'b0, 64'h2000, 64'h0, 2'd0, 5'd1, 2'd0, 5'd7, 5'd0, 5'd7,
      64'h0, 64'h0, 1'b0, 1'b0, 64'h0, 1'b1},
    // R6 doubleword pair load
    '{2'd2, 2'd3, 1'b1, 1'b0, 1'b0, 64'h3000, 64'h0, 2'd0, 5'd0, 2'd3, 5'd2, 5'd3, 5'd1,
      64'h3030, 64'h3038, 1'b1, 1'b0, 64'h0, 1'b0},
    // R6 word pair load
    '{2'd2, 2'd2, 1'b1, 1'b0, 1'b0, 64'h3000, 64'h0, 2'd0, 5'd0, 2'd2, 5'd2, 5'd3, 5'd1,
      64'h3010, 64'h3014, 1'b1, 1'b0, 64'h0, 1'b0},
    // R7 R9 pair load rd==rd2 illegal
    '{2'd2, 2'd2, 1'b1, 1'b0, 1'b0, 64'h3000, 64'h0, 2'd0, 5'd0, 2'd0, 5'd2, 5'd2, 5'd1,
      64'h0, 64'h0, 1'b0, 1'b0, 64'h0, 1'b1},
    // R7 pair load rs==rd2 illegal
    '{2'd2, 2'd3, 1'b1, 1'b0, 1'b0, 64'h3000, 64'h0, 2'd0, 5'd0, 2'd0, 5'd2, 5'd1, 5'd1,
      64'h0, 64'h0, 1'b0, 1'b0, 64'h0, 1'b1},
    // R7 pair store with all registers equal is legal
    '{2'd2, 2'd2, 1'b0, 1'b0, 1'b0, 64'h3000, 64'h0, 2'd0, 5'd0, 2'd0, 5'd5, 5'd5, 5'd5,
      64'h3000, 64'h3004, 1'b1, 1'b0, 64'h0, 1'b0},
    // R12 reserved mode
    '{2'd3, 2'd2, 1'b1, 1'b0, 1'b0, 64'h3000, 64'h0, 2'd0, 5'd0, 2'd0, 5'd2, 5'd3, 5'd1,
      64'h0, 64'h0, 1'b0, 1'b0, 64'h0, 1'b1},
    // R12 pair of halfwords
    '{2'd2, 2'd1, 1'b0, 1'b0, 1'b0, 64'h3000, 64'h0, 2'd0, 5'd0, 2'd0, 5'd2, 5'd3, 5'd1,
      64'h0, 64'h0, 1'b0, 1'b0, 64'h0, 1'b1}
  };

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    req_mode = v.mode; req_size = v.size; req_is_load = v.ld; req_pre = v.pre;
    req_zext = v.zx; req_base = v.base; req_index = v.idx; req_shift = v.sh;
    req_imm5 = v.imm; req_sh2 = v.sh2; req_rd = v.rd; req_rd2 = v.rd2; req_rs = v.rs;
  endtask

  task automatic run_vec(input int n, input vec_t v);
    string t;
    @(negedge clk);
    drive(v);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    t = $sformatf("vec%0d first beat", n);
    chk(out_valid === 1'b1, {t, " valid R9"}, 64'(out_valid), 64'd1);
    chk(illegal === v.ill, {t, " illegal R5 R7 R12"}, 64'(illegal), 64'(v.ill));
    if (!v.ill) chk(out_addr === v.a1, {t, " addr R1 R2 R3 R6"}, out_addr, v.a1);
    chk(wb_en === v.wb, {t, " wb_en R4 R9"}, 64'(wb_en), 64'(v.wb));
    if (v.wb) begin
      chk(wb_data === v.wbd, {t, " wb_data R4"}, wb_data, v.wbd);
      chk(wb_reg === v.rs, {t, " wb_reg R4"}, 64'(wb_reg), 64'(v.rs));
    end
    @(negedge clk);
    if (v.two) begin
      chk(out_valid === 1'b1 && out_second === 1'b1, {t, " second beat flag R6"},
          {62'd0, out_valid, out_second}, 64'd3);
      chk(out_addr === v.a2, {t, " second addr R6"}, out_addr, v.a2);
      @(negedge clk);
    end
    chk(out_valid === 1'b0, {t, " no extra beat R9"}, 64'(out_valid), 64'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; req_valid = 1'b0; out_ready = 1'b1; n_valid = 1'b0;
    n_mode = 2'd0; n_size = 2'd3; n_base = 32'h0; n_index = 32'h0;
    drive(TBL[0]);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk(out_valid === 1'b0, "reset out_valid R11", 64'(out_valid), 64'd0);
    chk(wb_en === 1'b0, "reset wb_en R11", 64'(wb_en), 64'd0);
    chk(illegal === 1'b0, "reset illegal R11", 64'(illegal), 64'd0);
    chk(req_ready === 1'b1, "reset req_ready R11", 64'(req_ready), 64'd1);

    for (int i = 0; i < NV; i++) run_vec(i, TBL[i]);

    // R10 backpressure on a doubleword pair
    out_ready = 1'b0;
    @(negedge clk);
    drive(TBL[7]);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < 3; k++) begin
      chk(out_valid === 1'b1 && out_addr === 64'h3030, "held first beat R10", out_addr, 64'h3030);
      chk(req_ready === 1'b0, "req_ready low while stalled R10", 64'(req_ready), 64'd0);
      @(negedge clk);
    end
    out_ready = 1'b1;
    @(negedge clk);
    chk(out_second === 1'b1 && out_addr === 64'h3038, "second beat after release R10 R6", out_addr, 64'h3038);
    @(negedge clk);
    chk(out_valid === 1'b0 && req_ready === 1'b1, "idle after pair R10", 64'(out_valid), 64'd0);

    // R8 doubleword indexed on 32-bit datapath
    n_mode = 2'd0; n_size = 2'd3; n_base = 32'h100; n_index = 32'h4;
    n_valid = 1'b1;
    @(negedge clk);
    n_valid = 1'b0;
    chk(n_ill === 1'b1, "narrow doubleword indexed illegal R8", 64'(n_ill), 64'd1);
    @(negedge clk);
    // R8 word indexed on 32-bit datapath is legal
    n_size = 2'd2;
    n_valid = 1'b1;
    @(negedge clk);
    n_valid = 1'b0;
    chk(n_ill === 1'b0 && n_addr === 32'h110, "narrow word indexed R8 R1", 64'(n_addr), 64'h110);
    @(negedge clk);
    // R8 doubleword pair on 32-bit datapath
    n_mode = 2'd2; n_size = 2'd3;
    n_valid = 1'b1;
    @(negedge clk);
    n_valid = 1'b0;
    chk(n_ill === 1'b1 && n_wb === 1'b0, "narrow doubleword pair illegal R8", 64'(n_ill), 64'd1);
    @(negedge clk);
    chk(n_second === 1'b0, "narrow illegal pair no second beat R9", 64'(n_second), 64'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule